// File: doc/BRIEF.md
# Quad DAC Serial Command Receiver

This block is the digital front end of a four-channel, 8-bit voltage DAC. A host writes a 16-bit command word over a slow serial link made of a select line, a frame-sync line, a serial clock and a data line. The receiver samples these pins in its own fast system clock, assembles the word, decodes a channel address, a power-down request, a speed flag and an 8-bit code, and drives the code latches that feed the analog converters.

Each channel has a pending register, which takes every decoded word, and an output latch, which feeds the converter. A hold pin freezes the output latches, so several channels can be loaded and then released together. An active-low power-down pin forces the power-down output regardless of the software request. The system clock must run at least four times faster than the serial clock, because all pins pass through two-flop synchronisers and edges are found in the system clock domain.

Top module: `qdac_rx`

## Requirements
- R1: After reset, all four channel codes are 0, `fast_mode` is 0, and `powered_down` is 0 while `pwrdn_n` is high.
- R2: A frame starts on a falling edge of `frm_sync` while `sel_n` is low. Data bits are taken MSB first on falling edges of `ser_clk`. Frame bits 15:14 are the channel address, where 00 selects channel 0 (bits 7:0 of `dac_code`), 01 selects channel 1 (bits 15:8), 10 selects channel 2 (bits 23:16) and 11 selects channel 3 (bits 31:24). Frame bits 11:4 carry the 8-bit code.
- R3: A full 16-bit word is not applied at its sixteenth falling `ser_clk` edge. It is applied after the next rising `ser_clk` edge.
- R4: If `frm_sync` rises after at least one bit and before sixteen bits, the word is applied at once. Bits not yet received read as zero. If `frm_sync` rises before any bit arrives, no word is applied.
- R5: While `sel_n` is high, serial activity changes nothing. If `sel_n` rises in mid-frame, the partial word is dropped and has no effect.
- R6: Frame bit 13 is the shared power-down request (1 = power down) and frame bit 12 is the shared speed flag (1 = fast, shown on `fast_mode`). Both are taken from every applied word, whatever its address.
- R7: While `hold_upd` is high, channel codes do not change and applied words only update the pending registers. When `hold_upd` goes low, all pending codes reach `dac_code` in the same clock cycle.
- R8: `powered_down` is high whenever `pwrdn_n` is low, whatever the power-down request. Otherwise it follows the request bit.
- R9: Frame bits 3:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| frm_sync | input | 1 | Frame sync; a falling edge starts a frame, a rising edge ends it early |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data, MSB first |
| hold_upd | input | 1 | High holds the output latches; low lets them follow the pending registers |
| pwrdn_n | input | 1 | Active-low forced power-down |
| dac_code | output | 32 | Four 8-bit channel codes, channel 0 in the low byte |
| fast_mode | output | 1 | Shared speed flag |
| powered_down | output | 1 | Power-down state |

## Verification
The bench sweeps codes across every channel with varied control and padding bits. It checks that untouched channels keep their values, which catches address decode or field slicing errors. It samples between the sixteenth falling edge and the following rising edge; a design that commits early fails there. Early-ended frames of several lengths check zero fill of the missing bits, and an empty frame must change nothing. The bench also checks that a select drop in mid-frame leaves no partial write, and that releasing the hold moves all four channels in one cycle rather than staggered. Finally it checks that the power-down pin wins over a cleared software request.

// File: rtl/qdac_pkg.sv
// Shared constants and the decoded command type for the quad DAC receiver.
package qdac_pkg;
    localparam int NCH     = 4;
    localparam int CODE_W  = 8;
    localparam int ADDR_W  = $clog2(NCH);
    localparam int FRAME_W = 16;
    // Fields kept from the frame: address, power request, speed, code.
    localparam int KEEP_W  = ADDR_W + 2 + CODE_W;
    localparam int PAD_W   = FRAME_W - KEEP_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              pwr;
        logic              spd;
        logic [CODE_W-1:0] code;
    } cmd_t;
endpackage

// File: rtl/qdac_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives the idle level of each pin.
module qdac_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;

    // Two-stage capture into the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            d_out  <= RST_VAL;
        end else begin
            meta_q <= d_in;
            d_out  <= meta_q;
        end
    end
endmodule

// File: rtl/qdac_framer.sv
// Serial framer: finds edges of the synchronised serial pins, collects the
// kept frame bits MSB first and emits a one-cycle command pulse.
// Assumes the system clock runs at least 4x the serial clock.
module qdac_framer
    import qdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,
    input  logic fs_s,
    input  logic sck_s,
    input  logic din_s,
    output logic cmd_valid,
    output cmd_t cmd
);
    logic              fs_q, sck_q;
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [KEEP_W-1:0] shreg;
    logic [KEEP_W-1:0] bit_mask;

    wire fs_fall  = fs_q & ~fs_s;
    wire fs_rise  = ~fs_q & fs_s;
    wire sck_fall = sck_q & ~sck_s;
    wire sck_rise = ~sck_q & sck_s;

    // Previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            fs_q  <= fs_s;
            sck_q <= sck_s;
        end
    end

    // Select the kept bit written by the current frame position.
    always_comb begin
        for (int i = 0; i < KEEP_W; i++)
            bit_mask[i] = (cnt == CNT_W'(FRAME_W - 1 - PAD_W - i));
    end

    // Frame control: start, shift, full-length or early commit, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (sel_s) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (fs_fall) begin
                active <= 1'b1;
                cnt    <= '0;
                shreg  <= '0;
            end else if (active) begin
                if (fs_rise) begin
                    active <= 1'b0;
                    if (cnt != '0) begin
                        cmd_valid <= 1'b1;
                        cmd       <= cmd_t'(shreg);
                    end
                end else if (cnt == CNT_W'(FRAME_W) && sck_rise) begin
                    active    <= 1'b0;
                    cmd_valid <= 1'b1;
                    cmd       <= cmd_t'(shreg);
                end else if (sck_fall && cnt < CNT_W'(FRAME_W)) begin
                    shreg <= (shreg & ~bit_mask) | (bit_mask & {KEEP_W{din_s}});
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    // R3
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R5
    sel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !cmd_valid);
endmodule

// File: rtl/qdac_bank.sv
// Channel bank: pending registers, held output latches and shared control.
// Assumes cmd_valid is a single-cycle pulse from the framer.
module qdac_bank
    import qdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  cmd_t                 cmd,
    input  logic                 hold_s,
    input  logic                 pwrdn_s,
    output logic [NCH*CODE_W-1:0] code_bus,
    output logic                 spd_r,
    output logic                 pd_r
);
    logic pwr_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CODE_W-1:0] pend_q, out_q;

        // Pending register takes every word addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q <= '0;
            else if (cmd_valid && cmd.addr == ADDR_W'(ch))
                pend_q <= cmd.code;
        end

        // Output latch follows the pending value while not held.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_q <= '0;
            else if (!hold_s)
                out_q <= pend_q;
        end

        assign code_bus[ch*CODE_W +: CODE_W] = out_q;
    end

    // Shared control bits from every applied word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_r <= 1'b0;
            spd_r <= 1'b0;
        end else if (cmd_valid) begin
            pwr_r <= cmd.pwr;
            spd_r <= cmd.spd;
        end
    end

    // Power-down output: pin overrides the software request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_r <= 1'b0;
        else
            pd_r <= pwr_r | ~pwrdn_s;
    end

    // R6
    spd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (spd_r == $past(cmd.spd)));
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_s |=> $stable(code_bus));
    // R8
    pin_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_s |=> pd_r);
endmodule

// File: rtl/qdac_rx.sv
// Quad DAC serial command receiver top: synchronises the pins, frames the
// serial word and drives the four channel code latches.
// Assumes clk is at least 4x ser_clk; the pins are asynchronous.
module qdac_rx
    import qdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n,
    input  logic                  frm_sync,
    input  logic                  ser_clk,
    input  logic                  ser_din,
    input  logic                  hold_upd,
    input  logic                  pwrdn_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic                  fast_mode,
    output logic                  powered_down
);
    localparam int NPIN = 6;
    localparam logic [NPIN-1:0] PIN_IDLE = 6'b110001;

    logic [NPIN-1:0] pins_s;
    logic            sel_s, fs_s, sck_s, din_s, hold_s, pwrdn_s;
    logic            cmd_valid;
    cmd_t            cmd;

    qdac_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sel_n, frm_sync, ser_clk, ser_din, hold_upd, pwrdn_n}),
        .d_out (pins_s)
    );

    assign {sel_s, fs_s, sck_s, din_s, hold_s, pwrdn_s} = pins_s;

    qdac_framer framer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (sel_s),
        .fs_s      (fs_s),
        .sck_s     (sck_s),
        .din_s     (din_s),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    qdac_bank bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .hold_s    (hold_s),
        .pwrdn_s   (pwrdn_s),
        .code_bus  (dac_code),
        .spd_r     (fast_mode),
        .pd_r      (powered_down)
    );
endmodule

// File: tb/qdac_rx_tb_top.sv
module qdac_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b0;
    logic        frm_sync = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        hold_upd = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic [31:0] dac_code;
    logic        fast_mode, powered_down;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_out [4];
    logic [7:0] exp_pend[4];
    logic       exp_pwr = 1'b0;
    logic       exp_spd = 1'b0;

    always #2 clk = ~clk;

    qdac_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .frm_sync(frm_sync),
        .ser_clk(ser_clk), .ser_din(ser_din), .hold_upd(hold_upd),
        .pwrdn_n(pwrdn_n), .dac_code(dac_code), .fast_mode(fast_mode),
        .powered_down(powered_down)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++)
            chk(req, {24'b0, dac_code[c*8 +: 8]}, {24'b0, exp_out[c]});
        chk(req, {31'b0, fast_mode}, {31'b0, exp_spd});
        chk(req, {31'b0, powered_down}, {31'b0, exp_pwr | ~pwrdn_n});
    endtask

    // Reference model: apply the first nbits of w, missing bits zero.
    task automatic model_word(input logic [15:0] w, input int nbits);
        logic [15:0] m;
        int a;
        if (nbits == 0) return;
        m = w & ~(16'hFFFF >> nbits);
        a = int'(m[15:14]);
        exp_pend[a] = m[11:4];
        exp_pwr = m[13];
        exp_spd = m[12];
        if (!hold_upd) exp_out[a] = exp_pend[a];
    endtask

    // Shift nbits of w; full frames get the trailing rising edge.
    task automatic send(input logic [15:0] w, input int nbits, input bit r3_probe);
        frm_sync = 1'b0;
        tick(8);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b1;
            ser_din = w[15-i];
            tick(8);
            ser_clk = 1'b0;
            tick(8);
        end
        if (nbits == 16) begin
            if (r3_probe) check_all("R3 before rising edge");
            ser_clk = 1'b1;
            tick(8);
            ser_clk = 1'b0;
            tick(8);
        end
        frm_sync = 1'b1;
        tick(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        for (int c = 0; c < 4; c++) begin exp_out[c] = 8'h00; exp_pend[c] = 8'h00; end
        tick(5);
        rst_n = 1'b1;
        tick(6);
        check_all("R1 reset");

        // R2 R6 R9 sweep over channels, codes, control and padding bits
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 256; v += 17) begin
                w = {c[1:0], v[0] ^ c[0], v[1], v[7:0] ^ 8'h5A, v[3:0] ^ 4'h9};
                send(w, 16, 1'b0);
                model_word(w, 16);
                check_all("R2 R6 sweep");
            end
        end

        // R9 padding has no effect
        w = {2'b01, 1'b0, 1'b0, 8'h3C, 4'hF};
        send(w, 16, 1'b0); model_word(w, 16);
        check_all("R9 pad F");
        w = {2'b01, 1'b0, 1'b0, 8'h3C, 4'h0};
        send(w, 16, 1'b0); model_word(w, 16);
        check_all("R9 pad 0");

        // R3 commit only after rising edge following bit 16
        w = {2'b11, 1'b0, 1'b1, 8'hE7, 4'h0};
        send(w, 16, 1'b1); model_word(w, 16);
        check_all("R3 after rising edge");

        // R4 early end with several lengths
        for (int n = 3; n <= 15; n += 3) begin
            w = {2'b10, 1'b1, 1'b1, 8'hFF, 4'hF};
            send(w, n, 1'b0); model_word(w, n);
            check_all("R4 early end");
        end
        send(16'hFFFF, 0, 1'b0);
        check_all("R4 empty frame");

        // R5 select high ignores whole frame
        sel_n = 1'b1; tick(4);
        send({2'b00, 1'b1, 1'b1, 8'h99, 4'h0}, 16, 1'b0);
        sel_n = 1'b0; tick(4);
        check_all("R5 deselected frame");
        // R5 select drop mid-frame
        frm_sync = 1'b0; tick(8);
        for (int i = 0; i < 8; i++) begin
            ser_clk = 1'b1; ser_din = 1'b1; tick(8);
            ser_clk = 1'b0; tick(8);
        end
        sel_n = 1'b1; tick(8);
        frm_sync = 1'b1; tick(8);
        sel_n = 1'b0; tick(8);
        check_all("R5 aborted frame");

        // R7 hold then simultaneous release
        hold_upd = 1'b1; tick(4);
        for (int c = 0; c < 4; c++) begin
            w = {c[1:0], 1'b0, 1'b0, ~exp_out[c], 4'h0};
            send(w, 16, 1'b0); model_word(w, 16);
        end
        check_all("R7 held");
        hold_upd = 1'b0;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 20 && !seen; k++) begin
                tick(1);
                if (dac_code != {exp_out[3], exp_out[2], exp_out[1], exp_out[0]}) begin
                    seen = 1'b1;
                    chk("R7 simultaneous", dac_code,
                        {exp_pend[3], exp_pend[2], exp_pend[1], exp_pend[0]});
                end
            end
            chk("R7 release seen", {31'b0, seen}, 32'd1);
        end
        for (int c = 0; c < 4; c++) exp_out[c] = exp_pend[c];
        check_all("R7 released");

        // R8 pin override
        pwrdn_n = 1'b0; tick(6);
        chk("R8 pin low", {31'b0, powered_down}, 32'd1);
        pwrdn_n = 1'b1; tick(6);
        chk("R8 pin high", {31'b0, powered_down}, {31'b0, exp_pwr});
        w = {2'b00, 1'b1, 1'b0, 8'h12, 4'h0};
        send(w, 16, 1'b0); model_word(w, 16);
        check_all("R8 R6 request bit");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule